// File: doc/BRIEF.md
# Nine-bit multiprocessor UART receiver

This block receives asynchronous serial frames of eight or nine data bits and flags them to a host through a receive-pending flag. It samples the serial line on a one-cycle tick supplied at sixteen times the bit rate by an outside baud generator. It shifts the data in least significant bit first and keeps the last accepted byte and ninth bit on its outputs. When enabled, it also checks parity.

On a shared multiprocessor bus, an address frame carries a one in the ninth bit and a data frame carries a zero there. A listener that runs the address-filtering mode (mode code 2) is woken only by address frames. After it recognises its own address it switches to the accept-all nine-bit mode (mode code 3) so that the data frames that follow reach it. A listener that is not addressed stays in mode 2 and sees none of the data traffic. Any change of the mode code restarts the receiver. Clearing the receive enable stops the receiver.

The controller has five states. ST_IDLE goes to ST_START on a falling line edge seen on a tick, provided the receiver is running. ST_START goes back to ST_IDLE on a false start, or on to ST_DATA once the start bit is confirmed low at mid-bit. ST_DATA goes to ST_NINTH after the eighth bit in the nine-bit modes, and to ST_STOP after the eighth bit in mode 1. ST_NINTH goes to ST_STOP. ST_STOP goes to ST_IDLE at the stop sample, whatever the line level. From any state the controller returns to ST_IDLE at once when the receiver stops running, which happens when the enable is low, when the mode changes or when the mode is 0.

Top module: `mpr_rx`

## Requirements
- R1: After reset, `ri`, `par_err`, `rx_bit9` and `rx_data` are all zero.
- R2: In mode 1 (`mode`=01) a frame is one low start bit, eight data bits LSB first and a high stop bit. Each bit lasts 16 ticks and is sampled at tick 8 of its period. A valid frame sets `ri`, loads `rx_data` and sets `rx_bit9` to 0.
- R3: In mode 2 (`mode`=10) a nine-bit frame whose ninth bit is 1 sets `ri` and loads `rx_data` and `rx_bit9`. A frame whose ninth bit is 0 leaves `ri`, `rx_data`, `rx_bit9` and `par_err` unchanged.
- R4: In mode 3 (`mode`=11) every valid nine-bit frame sets `ri` and loads `rx_data`, with the ninth bit on `rx_bit9`.
- R5: A low pulse on the line that ends before the mid-bit sample of the start bit, which is the 8th tick after the edge, is dropped without setting `ri`.
- R6: A frame whose stop bit is sampled low is discarded. Flags and data stay unchanged.
- R7: With `par_en`=1 in mode 1 or mode 3, an accepted frame sets `par_err` when the parity of its checked bits differs from `par_odd`, where 1 means odd and 0 means even. In mode 1 the checked bits are the eight data bits, with bit 7 acting as the parity bit. In mode 3 they are the eight data bits plus the ninth bit. Otherwise `par_err` is cleared. In mode 2, `par_err` is never set.
- R8: While `rx_en` is 0 the controller is in ST_IDLE. A frame that is cut off or sent while the enable is low sets no flag and changes no data.
- R9: A change of `mode` aborts any reception in progress and clears `ri` and `par_err` on the next cycle.
- R10: `ri` stays set until a cycle with `ri_clr`=1, which clears both `ri` and `par_err`. A frame accepted while `ri` is still set overwrites `rx_data` and `rx_bit9`.
- R11: In mode 0 (`mode`=00) the receiver starts no reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| mode | input | 2 | Mode code: 00 off, 01 eight-bit, 10 address-filtered nine-bit, 11 nine-bit |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| ri_clr | input | 1 | Clears the pending and parity-error flags |
| rx_data | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Last accepted ninth bit |
| ri | output | 1 | Receive pending flag |
| par_err | output | 1 | Parity error of the last accepted frame |

## Verification
The assertions take for granted that `tick` is a single-cycle strobe and that `mode`, `par_en` and `par_odd` are held steady while a frame arrives. The only exception is a deliberate mode change, which is treated as an abort. They also assume `ri_clr` is a short pulse. The stimulus drives each line bit for exactly 16 ticks. It changes the mode and the parity settings only between frames, except for the directed abort cases. In those cases the frame body is all zeros, so the line makes no falling edge after the abort that could look like a new start bit.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    typedef enum logic [1:0] {
        MD_SHIFT = 2'b00,
        MD_UART8 = 2'b01,
        MD_ADDR9 = 2'b10,
        MD_ALL9  = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } rx_state_e;

endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    // idle-high line: reset to ones so no false edge after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/mpr_frame_fsm.sv
module mpr_frame_fsm
    import mpr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd_s,
    input  logic              run,
    input  logic              nine,
    output rx_state_e         st,
    output logic              done,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_b9
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] START_LIM = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] BIT_LIM   = CNT_W'(OVS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 1);

    rx_state_e          st_n;
    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   bcnt;
    logic [DATA_W-1:0]  shreg;
    logic               b9_q;
    logic               prev_q;
    logic               fall;
    logic               sample_now;

    assign fall       = tick && prev_q && !rxd_s;
    assign sample_now = tick && (st != ST_IDLE) &&
                        (cnt == ((st == ST_START) ? START_LIM : BIT_LIM));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:  if (fall) st_n = ST_START;
            ST_START: if (sample_now) st_n = rxd_s ? ST_IDLE : ST_DATA;
            ST_DATA:  if (sample_now && bcnt == LAST_BIT)
                          st_n = nine ? ST_NINTH : ST_STOP;
            ST_NINTH: if (sample_now) st_n = ST_STOP;
            ST_STOP:  if (sample_now) st_n = ST_IDLE;
        endcase
        if (!run) st_n = ST_IDLE;
    end

    // tick-rate line history for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    prev_q <= 1'b1;
        else if (tick) prev_q <= rxd_s;
    end

    // oversample counter, bit counter and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bcnt  <= '0;
            shreg <= '0;
            b9_q  <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            bcnt <= '0;
        end else if (tick) begin
            if (st == ST_IDLE || sample_now) cnt <= '0;
            else                             cnt <= cnt + 1'b1;
            if (sample_now) begin
                unique case (st)
                    ST_START: begin
                        bcnt <= '0;
                        b9_q <= 1'b0;
                    end
                    ST_DATA: begin
                        shreg <= {rxd_s, shreg[DATA_W-1:1]};
                        bcnt  <= bcnt + 1'b1;
                    end
                    ST_NINTH: b9_q <= rxd_s;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        done     = run && sample_now && (st == ST_STOP) && rxd_s;
        frm_data = shreg;
        frm_b9   = nine && b9_q;
    end
endmodule

// File: rtl/mpr_accept.sv
module mpr_accept
    import mpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             md,
    input  logic              abort,
    input  logic              done,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_b9,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              ri_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              ri,
    output logic              par_err,
    output logic              take
);
    logic par_chk;
    logic ones_odd;
    logic bad_par;

    always_comb begin
        unique case (md)
            MD_UART8: take = done;
            MD_ALL9:  take = done;
            MD_ADDR9: take = done && frm_b9;
            MD_SHIFT: take = 1'b0;
        endcase
        if (abort) take = 1'b0;
        par_chk  = par_en && (md == MD_UART8 || md == MD_ALL9);
        ones_odd = (^frm_data) ^ ((md == MD_ALL9) && frm_b9);
        bad_par  = par_chk && (ones_odd != par_odd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_bit9 <= 1'b0;
            ri      <= 1'b0;
            par_err <= 1'b0;
        end else if (abort) begin
            ri      <= 1'b0;
            par_err <= 1'b0;
        end else if (take) begin
            rx_data <= frm_data;
            rx_bit9 <= frm_b9;
            ri      <= 1'b1;
            par_err <= bad_par;
        end else if (ri_clr) begin
            ri      <= 1'b0;
            par_err <= 1'b0;
        end
    end
endmodule

// File: rtl/mpr_rx.sv
module mpr_rx
    import mpr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic [1:0]        mode,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              ri_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              ri,
    output logic              par_err
);
    mode_e             md;
    mode_e             mode_q;
    logic              abort;
    logic              run;
    logic              rxd_s;
    rx_state_e         st;
    logic              done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_b9;
    logic              take;

    assign md    = mode_e'(mode);
    assign abort = (md != mode_q);
    assign run   = rx_en && !abort && (md != MD_SHIFT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MD_SHIFT;
        else        mode_q <= md;
    end

    mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
    );

    mpr_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_s(rxd_s),
        .run(run), .nine(md[1]), .st(st), .done(done),
        .frm_data(frm_data), .frm_b9(frm_b9)
    );

    mpr_accept #(.DATA_W(DATA_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .md(md), .abort(abort), .done(done),
        .frm_data(frm_data), .frm_b9(frm_b9), .par_en(par_en),
        .par_odd(par_odd), .ri_clr(ri_clr), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .ri(ri), .par_err(par_err), .take(take)
    );
endmodule

// File: rtl/mpr_rx_chk.sv
module mpr_rx_chk
    import mpr_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic [1:0] mode,
    input logic      rx_en,
    input logic      ri_clr,
    input logic      ri,
    input logic      rx_bit9,
    input logic      par_err,
    input rx_state_e st,
    input logic      take
);
    a_r3_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ri && !$past(ri) && $past(mode) == 2'b10) |-> rx_bit9);

    a_r6_set_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (ri && !$past(ri)) |-> $past(st == ST_STOP));

    a_r7_no_par_mode2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && $past(mode) == 2'b10) |-> !par_err);

    a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (st == ST_IDLE));

    a_r9_mode_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |=> (!ri && !par_err));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_clr && !take) |=> (!ri && !par_err));

    a_r11_mode0_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (st == ST_IDLE));
endmodule

bind mpr_rx mpr_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_en(rx_en),
    .ri_clr(ri_clr), .ri(ri), .rx_bit9(rx_bit9), .par_err(par_err),
    .st(st), .take(take)
);

// File: tb/sim_mpr_rx.sv
module sim_mpr_rx;
    localparam int BITCLK = 64;   // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       rx_en = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       ri_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       ri;
    logic       par_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [1:0] tdiv = '0;

    logic [7:0] e_data = '0;
    logic       e_b9 = 1'b0;
    logic       e_ri = 1'b0;
    logic       e_pe = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        tdiv <= tdiv + 1'b1;
        tick <= (tdiv == 2'd3);
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    mpr_rx u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .mode(mode),
        .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd), .ri_clr(ri_clr),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .ri(ri), .par_err(par_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, {31'd0, ri}, {31'd0, e_ri});
        check(req, {24'd0, rx_data}, {24'd0, e_data});
        check(req, {31'd0, rx_bit9}, {31'd0, e_b9});
        check(req, {31'd0, par_err}, {31'd0, e_pe});
    endtask

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (BITCLK) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] d, input logic b9, input logic stop_v);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        if (mode[1]) drive_bit(b9);
        drive_bit(stop_v);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    // expected effect of one complete frame, from the requirements
    function automatic logic ones_mismatch(input logic [7:0] d, input logic b9);
        logic s;
        s = ^d;
        if (mode == 2'b11) s = s ^ b9;
        return s != par_odd;
    endfunction

    task automatic model(input logic [7:0] d, input logic b9, input logic stop_v);
        logic acc;
        acc = stop_v && rx_en &&
              ((mode == 2'b01) || (mode == 2'b11) || (mode == 2'b10 && b9));
        if (acc) begin
            e_ri   = 1'b1;
            e_data = d;
            e_b9   = mode[1] ? b9 : 1'b0;
            e_pe   = par_en && (mode == 2'b01 || mode == 2'b11) && ones_mismatch(d, b9);
        end
    endtask

    task automatic frame(input logic [7:0] d, input logic b9, input logic stop_v);
        send(d, b9, stop_v);
        model(d, b9, stop_v);
    endtask

    task automatic set_mode(input logic [1:0] m);
        if (m != mode) begin
            mode = m;
            e_ri = 1'b0;
            e_pe = 1'b0;
        end
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic clear_ri(input string req);
        ri_clr = 1'b1;
        @(posedge clk); #1;
        ri_clr = 1'b0;
        @(posedge clk); #1;
        e_ri = 1'b0;
        e_pe = 1'b0;
        check(req, {31'd0, ri}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check_all("R1 after release");

        // R2 eight-bit frames, R10 overwrite then clear
        set_mode(2'b01);
        frame(8'hA5, 1'b0, 1'b1);
        check_all("R2 mode1 frame A5");
        frame(8'h3C, 1'b0, 1'b1);
        check_all("R10 overwrite while pending");
        clear_ri("R10 clear");

        // R3 address filtering
        set_mode(2'b10);
        frame(8'h11, 1'b0, 1'b1);
        check_all("R3 data frame filtered");
        frame(8'h42, 1'b1, 1'b1);
        check_all("R3 address frame accepted");
        clear_ri("R10 clear");

        // R4 accept all nine-bit frames
        set_mode(2'b11);
        frame(8'h55, 1'b0, 1'b1);
        check_all("R4 mode3 data frame");
        clear_ri("R10 clear");

        // R5 false start: low for 3 ticks only
        rxd = 1'b0;
        repeat (12) @(posedge clk);
        #1;
        rxd = 1'b1;
        repeat (3 * BITCLK) @(posedge clk);
        #1;
        check_all("R5 false start");

        // R6 stop bit low
        frame(8'h99, 1'b1, 1'b0);
        check_all("R6 bad stop discarded");

        // R7 parity
        par_en = 1'b1; par_odd = 1'b1;
        frame(8'h01, 1'b0, 1'b1);
        check_all("R7 mode3 odd ok");
        frame(8'h01, 1'b1, 1'b1);
        check_all("R7 mode3 odd error");
        clear_ri("R10 clear");
        set_mode(2'b01);
        par_odd = 1'b0;
        frame(8'h03, 1'b0, 1'b1);
        check_all("R7 mode1 even ok");
        frame(8'h07, 1'b0, 1'b1);
        check_all("R7 mode1 even error");
        set_mode(2'b10);
        frame(8'h07, 1'b1, 1'b1);
        check_all("R7 mode2 parity ignored");
        clear_ri("R10 clear");
        par_en = 1'b0;

        // R11 mode 0 receives nothing
        set_mode(2'b00);
        frame(8'hF0, 1'b1, 1'b1);
        check_all("R11 mode0 ignored");

        // R8 enable dropped mid-frame, then held low for a whole frame
        set_mode(2'b11);
        fork
            send(8'h00, 1'b1, 1'b1);
            begin
                repeat (300) @(posedge clk);
                #1;
                rx_en = 1'b0;
            end
        join
        rx_en = 1'b1;
        check_all("R8 abort by enable");
        rx_en = 1'b0;
        frame(8'h81, 1'b1, 1'b1);
        rx_en = 1'b1;
        check_all("R8 disabled frame ignored");

        // R9 mode change aborts and clears the flags
        par_en = 1'b1; par_odd = 1'b1;
        frame(8'h00, 1'b0, 1'b1);
        check_all("R9 setup pending with parity error");
        fork
            send(8'h00, 1'b1, 1'b1);
            begin
                repeat (300) @(posedge clk);
                #1;
                mode = 2'b01;
            end
        join
        e_ri = 1'b0;
        e_pe = 1'b0;
        check_all("R9 mode change abort");
        par_en = 1'b0;

        // constrained random frames
        for (int n = 0; n < 40; n++) begin
            logic [1:0] m;
            logic [7:0] d;
            logic b9, sv;
            m  = 2'($urandom_range(1, 3));
            d  = 8'($urandom);
            b9 = 1'($urandom);
            sv = ($urandom % 8) != 0;
            set_mode(m);
            par_en  = 1'($urandom);
            par_odd = 1'($urandom);
            frame(d, b9, sv);
            case (m)
                2'b01:   check_all("R2 R7 random mode1");
                2'b10:   check_all("R3 random mode2");
                default: check_all("R4 R7 random mode3");
            endcase
            if (($urandom % 2) == 0) clear_ri("R10 random clear");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule